// File: doc/BRIEF.md
# CAN bit timing sampler

This block splits every bit on a CAN receive line into time quanta and decides the value of each bit at a sample point that software can place. The quanta are counted from a one-cycle tick supplied by an external prescaler, so the block itself runs on the system clock and advances only when the tick is high. Each bit is made up of one synchronisation quantum, then segment 1 (propagation plus first phase segment), then phase segment 2. The bit value is taken where segment 1 ends. It is taken either from a single capture or as a 2-of-3 majority of the last three captures up to that point.

An 8-bit configuration register sets the two segment lengths and the sampling mode. It can always be read and is write-locked unless the top bit of a 3-bit mode input is set. The block checks the configuration against a static resynchronisation jump width input and flags configurations it cannot use. While the configuration is unusable or the mode input is in initialisation, the unit stays idle. From idle it starts on a recessive-to-dominant edge, which is a hard synchronisation. It goes back to idle after a run of recessive bits that marks the bus as free.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the register reads 0x00, `cfg_bad_o` is 1, `sample_o` and `bit_end_o` are 0, and `bit_o` is 1 (recessive).
- R2: A write through `cfg_wr_i`/`cfg_wdata_i` updates the register, as seen on `cfg_rdata_o` one cycle later, only when `mode_i[2]` is 1. With `mode_i[2]` at 0 the write is ignored and the register keeps its value.
- R3: Register bits 3:0 give segment 1 as field+1 quanta and bits 6:4 give phase segment 2 as field+1 quanta. A bit lasts 1+seg1+seg2 ticks. `bit_end_o` pulses for one clock in the cycle after the tick that ends the last quantum of phase segment 2.
- R4: Quanta are numbered from 0, where quantum 0 is the synchronisation quantum. `sample_o` pulses for one clock in the cycle after the tick that ends quantum seg1.
- R5: With register bit 7 at 0, `bit_o` takes the value of `rx_i` at that sample tick and holds it until the next sample.
- R6: With register bit 7 at 1, `rx_i` is captured at the ticks ending quanta seg1-2, seg1-1 and seg1, and `bit_o` takes the 2-of-3 majority of those captures.
- R7: The configuration is valid only when both fields are non-zero, seg2 > SJW (SJW = `sjw_i`+1 quanta), seg1 >= seg2 and 1+seg1+seg2 >= 8. `cfg_bad_o` shows the inverse of this one cycle after the register or `sjw_i` changes.
- R8: While the configuration is invalid, or `mode_i[2]` is 1, the unit is idle and neither strobe pulses, whatever `rx_i` and `tq_tick_i` do.
- R9: When the unit is idle, `rx_i` at 1 in one cycle and 0 in the next starts a bit: the next tick ends the synchronisation quantum. Falling edges while a bit is running do not move the count.
- R10: After IDLE_BITS consecutive bits sampled as 1, the unit returns to idle at the end of the last of them. It then produces no strobes until the next falling edge.
- R11: Strobes appear only in the cycle right after a cycle with `tq_tick_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode; bit 2 high means initialisation |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Current configuration register contents |
| sjw_i | input | 2 | Static jump width, value+1 quanta |
| tq_tick_i | input | 1 | One-cycle time-quantum tick from the prescaler |
| rx_i | input | 1 | Receive line, 1 recessive, 0 dominant |
| bit_o | output | 1 | Last sampled bit value |
| sample_o | output | 1 | One-cycle pulse when a bit has been sampled |
| bit_end_o | output | 1 | One-cycle pulse at the end of each bit |
| cfg_bad_o | output | 1 | Configuration unusable |

## Verification
The timing is exercised with the shortest legal bit of 8 quanta, the longest of 25 and random legal mixes in between, with random idle gaps between ticks. The gaps show whether counting follows the tick or the clock. Noise is injected into the receive line one quantum at a time around the sample point. Single-capture mode, where only the final capture may decide the bit, is thereby told apart from three-capture voting, where one flipped capture must be outvoted, and an off-by-one window is exposed. Boundary configurations for each validity rule, writes with the mode locked, and invalid or initialisation states with live edges show whether the lock and the idle gating hold. A long recessive run followed by a fresh falling edge shows the return to idle and the hard synchronisation restart.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;
  localparam int T1_W       = 4;
  localparam int T2_W       = 3;
  localparam int SJW_W      = 2;
  localparam int CFG_W      = 1 + T2_W + T1_W;
  localparam int MIN_BIT_TQ = 8;
  localparam int N_VOTE     = 3;
  localparam int MAX_BIT_TQ = 1 + (1 << T1_W) + (1 << T2_W);
  localparam int TQ_W       = $clog2(MAX_BIT_TQ + N_VOTE);

  typedef logic [TQ_W-1:0] tq_t;

  typedef struct packed {
    logic            triple;
    logic [T2_W-1:0] t2;
    logic [T1_W-1:0] t1;
  } cfg_t;

  typedef enum logic {ST_IDLE, ST_RUN} tstate_e;
endpackage

// File: rtl/can_bt_cfg.sv
`timescale 1ns/1ps
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [SJW_W-1:0] sjw_i,
  output cfg_t             cfg_o,
  output tq_t              seg1_o,
  output tq_t              bit_len_o,
  output logic             ok_o,
  output logic             bad_o
);
  cfg_t cfg_q;
  logic bad_q;
  tq_t  seg2, sjw_tq;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_i && init_i) begin
      cfg_q <= cfg_t'(wdata_i);
    end
  end

  always_comb begin
    seg1_o    = tq_t'(cfg_q.t1) + tq_t'(1);
    seg2      = tq_t'(cfg_q.t2) + tq_t'(1);
    sjw_tq    = tq_t'(sjw_i) + tq_t'(1);
    bit_len_o = seg1_o + seg2 + tq_t'(1);
    ok_o      = (cfg_q.t1 != '0) && (cfg_q.t2 != '0) &&
                (seg2 > sjw_tq) && (seg1_o >= seg2) &&
                (bit_len_o >= tq_t'(MIN_BIT_TQ));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q <= 1'b1;
    end else begin
      bad_q <= ~ok_o;
    end
  end

  assign cfg_o = cfg_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/can_bt_timer.sv
`timescale 1ns/1ps
module can_bt_timer
  import can_bt_pkg::*;
#(
  parameter int IDLE_BITS = 11
)(
  input  logic clk,
  input  logic rst,
  input  logic run_en_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic vote_i,
  input  tq_t  seg1_i,
  input  tq_t  bit_len_i,
  output logic cap_o,
  output logic smp_o,
  output logic bit_end_o
);
  localparam int REC_W = $clog2(IDLE_BITS + 1);
  typedef logic [REC_W-1:0] rec_t;

  tstate_e state_q;
  tq_t     cnt_q;
  rec_t    rec_q;
  logic    rx_prev_q;
  logic    end_q;
  logic    fall, tick_run, at_last, rec_full;

  assign fall     = rx_prev_q & ~rx_i;
  assign tick_run = tick_i & run_en_i & (state_q == ST_RUN);
  assign at_last  = (cnt_q == bit_len_i - tq_t'(1));
  assign rec_full = (rec_q == rec_t'(IDLE_BITS));
  assign smp_o    = tick_run && (cnt_q == seg1_i);
  assign cap_o    = tick_run && (cnt_q + tq_t'(N_VOTE - 1) >= seg1_i) &&
                    (cnt_q <= seg1_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev_q <= 1'b1;
    end else begin
      rx_prev_q <= rx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      end_q   <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (!run_en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        rec_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (fall) begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
              rec_q   <= '0;
            end
          end
          default: begin
            if (tick_run) begin
              if (smp_o) begin
                if (!vote_i) begin
                  rec_q <= '0;
                end else if (!rec_full) begin
                  rec_q <= rec_q + rec_t'(1);
                end
              end
              if (at_last) begin
                cnt_q <= '0;
                end_q <= 1'b1;
                if (rec_full) begin
                  state_q <= ST_IDLE;
                end
              end else begin
                cnt_q <= cnt_q + tq_t'(1);
              end
            end
          end
        endcase
      end
    end
  end

  assign bit_end_o = end_q;
endmodule

// File: rtl/can_bt_vote.sv
`timescale 1ns/1ps
module can_bt_vote
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic triple_i,
  input  logic cap_i,
  input  logic smp_i,
  input  logic rx_i,
  output logic vote_o,
  output logic bit_o,
  output logic sample_o
);
  localparam int HIST_W = N_VOTE - 1;
  localparam int ONES_W = $clog2(N_VOTE + 1);

  logic [HIST_W-1:0] hist_q;
  logic [N_VOTE-1:0] window;
  logic [ONES_W-1:0] ones;
  logic              bit_q, smp_q;

  always_comb begin
    window = {hist_q, rx_i};
    ones   = '0;
    for (int i = 0; i < N_VOTE; i++) begin
      ones = ones + ONES_W'(window[i]);
    end
    vote_o = triple_i ? (ones > ONES_W'(N_VOTE / 2)) : rx_i;
  end

  generate
    if (HIST_W > 1) begin : g_hist_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= '1;
        end else if (cap_i) begin
          hist_q <= {hist_q[HIST_W-2:0], rx_i};
        end
      end
    end else begin : g_hist_one
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= '1;
        end else if (cap_i) begin
          hist_q <= rx_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b1;
      smp_q <= 1'b0;
    end else begin
      smp_q <= smp_i;
      if (smp_i) begin
        bit_q <= vote_o;
      end
    end
  end

  assign bit_o    = bit_q;
  assign sample_o = smp_q;
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int IDLE_BITS = 11
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             tq_tick_i,
  input  logic             rx_i,
  output logic             bit_o,
  output logic             sample_o,
  output logic             bit_end_o,
  output logic             cfg_bad_o
);
  cfg_t cfg;
  tq_t  seg1, bit_len;
  logic cfg_ok, run_en, cap, smp, vote;
  logic unused_mode;

  assign unused_mode = ^mode_i[1:0];
  assign run_en      = cfg_ok & ~mode_i[2];
  assign cfg_rdata_o = cfg;

  can_bt_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .init_i    (mode_i[2]),
    .wr_i      (cfg_wr_i),
    .wdata_i   (cfg_wdata_i),
    .sjw_i     (sjw_i),
    .cfg_o     (cfg),
    .seg1_o    (seg1),
    .bit_len_o (bit_len),
    .ok_o      (cfg_ok),
    .bad_o     (cfg_bad_o)
  );

  can_bt_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_en_i  (run_en),
    .tick_i    (tq_tick_i),
    .rx_i      (rx_i),
    .vote_i    (vote),
    .seg1_i    (seg1),
    .bit_len_i (bit_len),
    .cap_o     (cap),
    .smp_o     (smp),
    .bit_end_o (bit_end_o)
  );

  can_bt_vote u_vote (
    .clk      (clk),
    .rst      (rst),
    .triple_i (cfg.triple),
    .cap_i    (cap),
    .smp_i    (smp),
    .rx_i     (rx_i),
    .vote_o   (vote),
    .bit_o    (bit_o),
    .sample_o (sample_o)
  );
endmodule

// File: rtl/can_bt_checker.sv
`timescale 1ns/1ps
module can_bt_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_i,
  input logic       tq_tick_i,
  input logic [7:0] cfg_rdata_o,
  input logic       sample_o,
  input logic       bit_end_o,
  input logic       cfg_bad_o
);
  p_write_lock_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_i[2] |=> $stable(cfg_rdata_o));

  p_end_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    bit_end_o |-> $past(tq_tick_i));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && bit_end_o));

  p_zero_field_bad_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rdata_o[3:0]) == 4'd0 || $past(cfg_rdata_o[6:4]) == 3'd0) |-> cfg_bad_o);

  p_bad_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_bad_o |-> (!sample_o && !bit_end_o));

  p_init_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(mode_i[2]) |-> (!sample_o && !bit_end_o));

  p_sample_after_tick_r11: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> $past(tq_tick_i));
endmodule

bind can_bit_timer can_bt_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .tq_tick_i   (tq_tick_i),
  .cfg_rdata_o (cfg_rdata_o),
  .sample_o    (sample_o),
  .bit_end_o   (bit_end_o),
  .cfg_bad_o   (cfg_bad_o)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
  localparam int IDLE_BITS = 11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] sjw = 2'd0;
  logic       tq = 1'b0;
  logic       rx = 1'b1;
  logic       bit_v, smp, bend, bad;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  can_bit_timer #(.IDLE_BITS(IDLE_BITS)) u_can_bit_timer (
    .clk(clk), .rst(rst), .mode_i(mode), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .sjw_i(sjw), .tq_tick_i(tq), .rx_i(rx),
    .bit_o(bit_v), .sample_o(smp), .bit_end_o(bend), .cfg_bad_o(bad)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok(input logic [7:0] c, input logic [1:0] sj);
    int s1 = int'(c[3:0]) + 1;
    int s2 = int'(c[6:4]) + 1;
    int sw = int'(sj) + 1;
    return (c[3:0] != 0) && (c[6:4] != 0) && (s2 > sw) && (s1 >= s2) && (1 + s1 + s2 >= 8);
  endfunction

  task automatic set_cfg(input logic [7:0] d, input logic [1:0] sj, input bit stay_init);
    @(negedge clk);
    mode = 3'b100; wr = 1'b1; wdata = d; sjw = sj;
    @(negedge clk);
    wr = 1'b0;
    if (!stay_init) mode = 3'b000;
    @(negedge clk);
  endtask

  // one tick with line value v; outputs checked in the cycle after the tick
  task automatic tick_chk(input logic v, input bit es, input bit ee, input logic eb,
                          input string tag, input int gmax);
    tq = 1'b1; rx = v;
    @(negedge clk);
    tq = 1'b0;
    chk((smp == es) && (bend == ee), tag, {smp, bend}, {es, ee});
    if (es) chk(bit_v == eb, tag, bit_v, eb);
    repeat ($urandom_range(0, gmax)) begin
      @(negedge clk);
      chk(!smp && !bend, "R11 strobe without tick", {smp, bend}, 0);
    end
  endtask

  task automatic run_bits(input logic [7:0] c, input logic [1:0] sj, input int nbits,
                          input int pattern, input int gmax, input bit do_cfg);
    int s1 = int'(c[3:0]) + 1;
    int s2 = int'(c[6:4]) + 1;
    int len = 1 + s1 + s2;
    logic r0, r1, r2, eb;
    if (do_cfg) set_cfg(c, sj, 1'b0);
    rx = 1'b1;
    repeat (2) @(negedge clk);
    rx = 1'b0;                       // R9 hard synchronisation edge
    @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      logic v;
      bit noisy;
      if (pattern == 1) v = (b == 0) ? 1'b0 : 1'b1;
      else v = (b % 5 == 0) ? 1'b0 : 1'($urandom_range(0, 1));
      noisy = (pattern == 0) && (b % 5 != 0);
      r0 = v; r1 = v; r2 = v; eb = v;
      for (int p = 0; p < len; p++) begin
        logic x = v;
        if (noisy && p >= s1 - 2 && p <= s1 && $urandom_range(0, 3) == 0) x = ~v;
        if (p == s1 - 2) r0 = x;
        if (p == s1 - 1) r1 = x;
        if (p == s1) begin
          r2 = x;
          eb = c[7] ? ((int'(r0) + int'(r1) + int'(r2)) >= 2) : x;
        end
        tick_chk(x, p == s1, p == len - 1, eb,
                 c[7] ? "R3/R4/R6 three-sample timing" : "R3/R4/R5 single-sample timing", gmax);
      end
    end
  endtask

  function automatic logic [7:0] rand_valid(input logic [1:0] sj);
    logic [7:0] c;
    do c = 8'($urandom_range(0, 255)); while (!exp_ok(c, sj));
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C4B_17E5));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 8'h00, "R1 reset register", rdata, 0);
    chk(bad == 1'b1, "R1 reset bad flag", bad, 1);
    chk(!smp && !bend, "R1 reset strobes", {smp, bend}, 0);
    chk(bit_v == 1'b1, "R1 reset bit value", bit_v, 1);

    // R2 write lock
    mode = 3'b011; wr = 1'b1; wdata = 8'h5A;
    @(negedge clk); wr = 1'b0; @(negedge clk);
    chk(rdata == 8'h00, "R2 write outside init ignored", rdata, 0);
    set_cfg(8'h5A, 2'd0, 1'b0);
    chk(rdata == 8'h5A, "R2 write in init", rdata, 8'h5A);
    wr = 1'b1; wdata = 8'hA5;
    @(negedge clk); wr = 1'b0; @(negedge clk);
    chk(rdata == 8'h5A, "R2 write in normal mode ignored", rdata, 8'h5A);

    // R7 directed validity boundaries
    begin
      logic [7:0] dc [8] = '{8'h10, 8'h04, 8'h14, 8'h14, 8'h32, 8'h22, 8'h23, 8'hFF};
      logic [1:0] ds [8] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
      for (int i = 0; i < 8; i++) begin
        set_cfg(dc[i], ds[i], 1'b0);
        chk(bad == !exp_ok(dc[i], ds[i]), "R7 directed validity", bad, !exp_ok(dc[i], ds[i]));
      end
    end
    // R7 random validity
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c = 8'($urandom_range(0, 255));
      logic [1:0] s = 2'($urandom_range(0, 3));
      set_cfg(c, s, 1'b0);
      chk(bad == !exp_ok(c, s), "R7 random validity", bad, !exp_ok(c, s));
    end

    // timing: shortest bit, longest bit, then random legal settings
    run_bits(8'h14, 2'd0, 12, 0, 2, 1'b1);
    run_bits(8'h94, 2'd0, 12, 0, 0, 1'b1);
    run_bits(8'hFF, 2'd3, 8, 0, 1, 1'b1);
    run_bits(8'h7F, 2'd0, 8, 0, 3, 1'b1);
    for (int i = 0; i < 6; i++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      run_bits(rand_valid(s), s, 10, 0, 2, 1'b1);
    end

    // R8 invalid configuration stays quiet
    set_cfg(8'h00, 2'd0, 1'b0);
    chk(bad == 1'b1, "R8 invalid flagged", bad, 1);
    rx = 1'b1; repeat (2) @(negedge clk); rx = 1'b0; @(negedge clk);
    for (int i = 0; i < 30; i++) tick_chk(1'($urandom_range(0, 1)), 0, 0, 0, "R8 invalid quiet", 1);
    // R8 init mode stays quiet with a valid setting
    set_cfg(8'h14, 2'd0, 1'b1);
    chk(bad == 1'b0, "R8 valid in init", bad, 0);
    rx = 1'b1; repeat (2) @(negedge clk); rx = 1'b0; @(negedge clk);
    for (int i = 0; i < 30; i++) tick_chk(1'($urandom_range(0, 1)), 0, 0, 0, "R8 init quiet", 1);
    mode = 3'b000;
    @(negedge clk);

    // R10 recessive run returns to idle, R9 new edge restarts
    run_bits(8'h25, 2'd1, 1 + IDLE_BITS, 1, 1, 1'b1);
    for (int i = 0; i < 40; i++) tick_chk(1'b1, 0, 0, 0, "R10 idle after recessive run", 1);
    run_bits(8'h25, 2'd1, 4, 0, 1, 1'b0);
    run_bits(8'hB6, 2'd2, 1 + IDLE_BITS, 1, 0, 1'b1);
    for (int i = 0; i < 30; i++) tick_chk(1'b1, 0, 0, 0, "R10 idle after recessive run", 0);
    repeat (5) @(negedge clk);
    run_bits(8'hB6, 2'd2, 3, 0, 2, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule